// File: doc/BRIEF.md
# Address Match Breakpoint Unit

This block sits beside the fetch stage of a small processor core and watches the start address of every instruction the core is about to execute. Software loads two match addresses and turns each one on with its own enable bit. The core pulses an execute strobe for each instruction, together with that instruction's start address and first opcode byte. When the address equals an enabled match address, the block raises a break request before the instruction runs. The request does not pass through the core's interrupt-enable flag or its priority level.

With the request, the block gives the channel that matched and the program-counter value the core pushes to the stack. That value is not the real return address. It is the match address plus 1 or plus 2, chosen from the length class of the first opcode byte. A parameterised 256-entry bit mask holds that class table. The request stays up until the core acknowledges it. The stack push, the vector fetch and the return path belong to the core.

Top module: `brk_match_unit`

## Requirements
- R1: After reset `req_o` is 0, both match addresses are zero and both enables are 0, so a strobe at address 0 raises no request.
- R2: When `cfg_we_i` is 1 at a clock edge, `cfg_sel_i` picks the target. Value 0 writes the channel 0 match address and value 1 writes the channel 1 match address, using all 20 bits of `cfg_wdata_i`. Value 2 writes the enables: bit 0 of `cfg_wdata_i` enables channel 0 and bit 1 enables channel 1.
- R3: A strobe on `exec_i` whose `fetch_addr_i` equals an enabled match address sets `req_o` at that clock edge, so `req_o` is visible in the following cycle.
- R4: A strobe at an address that matches no enabled channel raises no request. This holds for a disabled channel whose address matches and for an address one byte off.
- R5: If bit `fetch_op_i` of the mask is set, `saved_pc_o` is the match address plus 2. The default mask sets opcode bytes 0x30 to 0x37 and 0xF0 to 0xFF.
- R6: For any other opcode byte, `saved_pc_o` is the match address plus 1. Both sums wrap modulo 2^20.
- R7: If both channels match the same strobe, one request is raised and `src_o` is 0. Otherwise `src_o` is the index of the matching channel.
- R8: `req_o` stays at 1 until a cycle with `ack_i` at 1. After that cycle it is 0, unless R10 applies.
- R9: While a request is pending and not acknowledged, further strobes are ignored. `src_o` and `saved_pc_o` keep their values.
- R10: If `ack_i` and a matching strobe occur in the same cycle, the new match wins. `req_o` stays at 1 and carries the new channel and saved PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Write target: 0 match 0, 1 match 1, 2 enables |
| cfg_wdata_i | input | 20 | Write data |
| fetch_addr_i | input | 20 | Start address of the instruction about to execute |
| fetch_op_i | input | 8 | First opcode byte of that instruction |
| exec_i | input | 1 | One-cycle strobe: the instruction is about to execute |
| ack_i | input | 1 | Core has taken the break request |
| req_o | output | 1 | Break request, ignores the interrupt mask |
| src_o | output | 1 | Channel that raised the request |
| saved_pc_o | output | 20 | Value for the core to push as PC |

## Verification
Two events can fall in the same cycle: the core's acknowledge of a pending break, and a new execute strobe that hits an enabled address. The bench raises a request, then drives `ack_i` together with a strobe on the other channel's address, using an opcode from the other length class. It then expects `req_o` to stay high, with `src_o` and `saved_pc_o` changed to the new channel's values. A second case uses the same pending request with a strobe and no acknowledge, and expects the old values to be held.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned OP_W = 8;
  // opcode bytes whose instruction reports match address + 2
  localparam logic [255:0] DEF_PLUS2_MASK = {
    64'hFFFF_0000_0000_0000,
    64'h0000_0000_0000_0000,
    64'h0000_0000_0000_0000,
    64'h00FF_0000_0000_0000
  };
endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [ADDR_W-1:0]             wdata_i,
  output logic [NUM_CH-1:0][ADDR_W-1:0] match_o,
  output logic [NUM_CH-1:0]             en_o
);
  localparam logic [SEL_W-1:0] EN_SEL = SEL_W'(NUM_CH);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        match_o[g] <= '0;
      else if (we_i && sel_i == MY_SEL)   match_o[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      en_o <= '0;
    else if (we_i && sel_i == EN_SEL) en_o <= wdata_i[NUM_CH-1:0];
  end
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SRC_W  = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] match_i,
  input  logic [NUM_CH-1:0]             en_i,
  output logic [NUM_CH-1:0]             hit_o,
  output logic                          any_o,
  output logic [SRC_W-1:0]              src_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign hit_o[g] = en_i[g] && (match_i[g] == addr_i);
  end

  assign any_o = |hit_o;

  // lowest index wins
  always_comb begin
    src_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hit_o[i]) src_o = SRC_W'(i);
    end
  end

  AST_SRC_IS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> hit_o[src_o]); // R7
endmodule

// File: rtl/brk_len_decode.sv
module brk_len_decode
  import brk_pkg::*;
#(
  parameter logic [255:0] PLUS2_MASK = DEF_PLUS2_MASK
) (
  input  logic [OP_W-1:0] op_i,
  output logic            plus2_o
);
  assign plus2_o = PLUS2_MASK[op_i];
endmodule

// File: rtl/brk_req_ctrl.sv
module brk_req_ctrl #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SRC_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic              ack_i,
  input  logic              hit_i,
  input  logic [SRC_W-1:0]  hit_src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              plus2_i,
  output logic              req_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [ADDR_W-1:0] pc_o
);
  logic              take;
  logic [ADDR_W-1:0] pc_next;

  assign take    = exec_i && hit_i && (!req_o || ack_i);
  assign pc_next = addr_i + (plus2_i ? ADDR_W'(2) : ADDR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      src_o <= '0;
      pc_o  <= '0;
    end else if (take) begin
      req_o <= 1'b1;
      src_o <= hit_src_i;
      pc_o  <= pc_next;
    end else if (ack_i) begin
      req_o <= 1'b0;
    end
  end

  AST_REQ_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(exec_i)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o); // R8
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !exec_i |=> !req_o); // R8
  AST_PENDING_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> $stable(pc_o) && $stable(src_o)); // R9
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
  import brk_pkg::*;
#(
  parameter int unsigned  ADDR_W     = 20,
  parameter int unsigned  NUM_CH     = 2,
  parameter logic [255:0] PLUS2_MASK = DEF_PLUS2_MASK,
  localparam int unsigned SRC_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned SEL_W      = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [OP_W-1:0]   fetch_op_i,
  input  logic              exec_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [ADDR_W-1:0] saved_pc_o
);
  logic [NUM_CH-1:0][ADDR_W-1:0] match;
  logic [NUM_CH-1:0]             en;
  logic [NUM_CH-1:0]             hit_vec;
  logic                          hit_any;
  logic [SRC_W-1:0]              hit_src;
  logic                          plus2;

  brk_cfg_regs #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .match_o(match), .en_o(en)
  );

  brk_addr_cmp #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SRC_W(SRC_W)) u_cmp (
    .clk_i, .rst_ni,
    .addr_i(fetch_addr_i), .match_i(match), .en_i(en),
    .hit_o(hit_vec), .any_o(hit_any), .src_o(hit_src)
  );

  brk_len_decode #(.PLUS2_MASK(PLUS2_MASK)) u_dec (
    .op_i(fetch_op_i), .plus2_o(plus2)
  );

  brk_req_ctrl #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_ctrl (
    .clk_i, .rst_ni,
    .exec_i, .ack_i,
    .hit_i(hit_any), .hit_src_i(hit_src),
    .addr_i(fetch_addr_i), .plus2_i(plus2),
    .req_o, .src_o, .pc_o(saved_pc_o)
  );

  AST_NO_HIT_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && !(exec_i && (hit_vec != '0)) |=> !req_o); // R4
endmodule

// File: tb/tb_brk_match_unit.sv
`timescale 1ns/1ps
module tb_brk_match_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [19:0] cfg_wdata_i = '0;
  logic [19:0] fetch_addr_i = '0;
  logic [7:0]  fetch_op_i = '0;
  logic        exec_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        req_o;
  logic [0:0]  src_o;
  logic [19:0] saved_pc_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  brk_match_unit dut (.*);

  // fields: addr(20) op(8) req(1) src(1) pc(20)
  localparam int NV = 8;
  localparam logic [49:0] VEC [NV] = '{
    {20'h01234, 8'h00, 1'b1, 1'b0, 20'h01235},
    {20'h01234, 8'h31, 1'b1, 1'b0, 20'h01236},
    {20'h0ABCD, 8'hF7, 1'b1, 1'b1, 20'h0ABCF},
    {20'h0ABCD, 8'h38, 1'b1, 1'b1, 20'h0ABCE},
    {20'h01235, 8'h00, 1'b0, 1'b0, 20'h00000},
    {20'h0ABCC, 8'h2F, 1'b0, 1'b0, 20'h00000},
    {20'h01234, 8'hFF, 1'b1, 1'b0, 20'h01236},
    {20'h0ABCD, 8'hEF, 1'b1, 1'b1, 20'h0ABCE}
  };

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [19:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic fire(input logic [19:0] a, input logic [7:0] op);
    fetch_addr_i = a; fetch_op_i = op; exec_i = 1'b1;
    step();
    exec_i = 1'b0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
  endtask

  initial begin
    repeat (1000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1: reset state
    check("R1 req after reset", 32'(req_o), 0);
    fire(20'h00000, 8'h00);
    check("R1 zero addr disabled", 32'(req_o), 0);

    // R2: program channels, enable only ch1 first
    wr(2'd0, 20'h01234);
    wr(2'd1, 20'h0ABCD);
    wr(2'd2, 20'h00002);
    fire(20'h01234, 8'h00);
    check("R4 disabled channel", 32'(req_o), 0);
    fire(20'h0ABCD, 8'h00);
    check("R2 ch1 enable bit1", 32'(req_o), 1);
    check("R2 ch1 src", 32'(src_o), 1);
    ack();
    wr(2'd2, 20'h00003);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      fire(VEC[i][49:30], VEC[i][29:22]);
      check($sformatf("R3 vec%0d req", i), 32'(req_o), 32'(VEC[i][21]));
      if (VEC[i][21]) begin
        check($sformatf("R7 vec%0d src", i), 32'(src_o), 32'(VEC[i][20]));
        check($sformatf("R5/R6 vec%0d pc", i), 32'(saved_pc_o), 32'(VEC[i][19:0]));
        ack();
        check($sformatf("R8 vec%0d cleared", i), 32'(req_o), 0);
      end
    end

    // R8: hold without ack
    fire(20'h01234, 8'h00);
    repeat (3) step();
    check("R8 held", 32'(req_o), 1);
    // R9: strobe while pending is ignored
    fire(20'h0ABCD, 8'hF0);
    check("R9 req", 32'(req_o), 1);
    check("R9 src kept", 32'(src_o), 0);
    check("R9 pc kept", 32'(saved_pc_o), 32'h01235);
    // R10: ack with new match
    fetch_addr_i = 20'h0ABCD; fetch_op_i = 8'hF0; exec_i = 1'b1; ack_i = 1'b1;
    step();
    exec_i = 1'b0; ack_i = 1'b0;
    check("R10 req stays", 32'(req_o), 1);
    check("R10 new src", 32'(src_o), 1);
    check("R10 new pc", 32'(saved_pc_o), 32'h0ABCF);
    ack();
    check("R8 ack drop", 32'(req_o), 0);

    // R7: both channels same address
    wr(2'd1, 20'h01234);
    fire(20'h01234, 8'h00);
    check("R7 both req", 32'(req_o), 1);
    check("R7 ch0 wins", 32'(src_o), 0);
    ack();

    // R5/R6 wrap
    wr(2'd0, 20'hFFFFF);
    fire(20'hFFFFF, 8'hF0);
    check("R5 wrap pc", 32'(saved_pc_o), 32'h00001);
    ack();
    fire(20'hFFFFF, 8'h00);
    check("R6 wrap pc", 32'(saved_pc_o), 32'h00000);
    ack();
    check("R8 final clear", 32'(req_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule